// File: doc/BRIEF.md
# Paged Management Register Slave

This block is the management-bus target of a pluggable transceiver. It listens on a two-wire serial bus (clock plus open-drain data) and answers only at one fixed device address. A write transaction sets an internal byte pointer and then stores bytes. A read transaction returns bytes starting at the pointer. Both kinds of transfer move the pointer forward one byte per data byte. The host reaches the 256-byte window with the usual random-read pattern: a write of the offset, a repeated start, then a read.

The lower half of the window (offsets 0 to 127) is a single fixed page that is always visible. The upper half (offsets 128 to 255) shows one of several pages, and a page-select byte held at the top of the lower half picks which one. One page is general-purpose user storage kept inside the block. A small range of other page numbers is passed out through a plain register-file port, which also serves the status, flag and control bytes of the lower page. Every other page number reads as zero and discards writes. An active-low select input gates the whole slave, so several modules can share one bus. All bus inputs are oversampled by the system clock.

Top module: `mgmt_i2c_slave`

## Requirements
- R1: While selected, the slave acknowledges an address byte whose upper seven bits equal the parameter DEV_ADDR (default 7'h50, so 8'hA0 for a write and 8'hA1 for a read, with bit 0 as the read flag). It leaves every other address byte unacknowledged and then ignores the bus until the next start.
- R2: While the select input is high, the slave never pulls SDA low and acknowledges nothing, and bus writes made during that time change no stored byte.
- R3: The slave changes its SDA drive only while SCL is low, so it never creates a start or stop condition itself.
- R4: In a write transaction, the first byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then advances.
- R5: In a read transaction, the slave sends the byte at the pointer MSB first and advances the pointer. A master acknowledge makes it send the next byte; a master no-acknowledge ends the transfer.
- R6: The pointer advances within its own 128-byte half: 127 is followed by 0, and 255 is followed by 128.
- R7: Offsets 0 to 126 use the register-file port with rf_upper_o=0 and rf_addr_o equal to the offset. Writes there raise rf_we_o for one cycle with rf_wdata_o set to the data byte.
- R8: Offset 127 is the page-select register. It resets to 0, reads back its value, is never passed to the register-file port, and applies from the next upper-half access on.
- R9: For offsets 128 to 255: if the page equals USER_PAGE (default 2), internal user storage is used for both reads and writes. If the page is below EXT_PAGES (default 2), the register-file port is used with rf_upper_o=1 and rf_page_o set to the page. Any other page reads as 8'h00 and ignores writes.
- R10: If the select input goes high during a transaction, the slave releases SDA and drops the transaction. Bits clocked after the select input goes low again are ignored until a new start.
- R11: A stop returns the slave to idle, so a byte clocked without a start gets no acknowledge. A repeated start at any point begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | High to pull SDA low (open-drain driver enable) |
| sel_n_i | input | 1 | Active-low module select |
| rf_upper_o | output | 1 | Register-file access targets an upper page |
| rf_page_o | output | 8 | Current page number for upper accesses |
| rf_addr_o | output | 7 | Byte offset within the half |
| rf_we_o | output | 1 | One-cycle write strobe to the register file |
| rf_wdata_o | output | 8 | Write data to the register file |
| rf_rdata_i | input | 8 | Read data from the register file (combinational) |

## Verification
The checker checks on every cycle that the SDA drive stays released while the select input is high, and that the drive is only taken while SCL is low. It also checks that each pointer step stays within its half, and that register-file write strobes never reach the page-select byte or an unserved page. Only the bench's bus scenarios can show the rest: whether the right bytes come back after writes, page switching and wraps at both half boundaries, whether a dropped transaction or a stray byte without a start leaves memory unchanged, and whether foreign addresses go unacknowledged.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int BYTE_W = 8;
  localparam int OFFS_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_WACK,
    ST_TX,
    ST_RACK
  } bus_st_e;

  typedef enum logic [2:0] {
    RG_LOW,
    RG_PSEL,
    RG_USER,
    RG_EXT,
    RG_NONE
  } region_e;

  // Device address match on the upper seven bits of the address byte.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] abyte,
                                    input logic [BYTE_W-2:0] dev);
    return abyte[BYTE_W-1:1] == dev;
  endfunction

  // Pointer advance that stays inside the current 128-byte half.
  function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] p);
    logic [OFFS_W-1:0] lo;
    lo = p[OFFS_W-1:0] + 1'b1;
    return {p[BYTE_W-1], lo};
  endfunction

  // Classify a pointer value against the current page selection.
  function automatic region_e region_of(input logic [BYTE_W-1:0] p,
                                        input logic [BYTE_W-1:0] page,
                                        input logic [BYTE_W-1:0] user_pg,
                                        input logic [BYTE_W-1:0] ext_cnt);
    if (!p[BYTE_W-1]) begin
      return (p[OFFS_W-1:0] == '1) ? RG_PSEL : RG_LOW;
    end
    if (page == user_pg) return RG_USER;
    if (page < ext_cnt) return RG_EXT;
    return RG_NONE;
  endfunction

endpackage

// File: rtl/mgmt_bus_sync.sv
module mgmt_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sel_n_i,
  output logic scl_s,
  output logic sda_s,
  output logic unsel,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh, sel_sh;
  logic scl_d, sda_d;

  // Synchronizer chains, idle level high for all three lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      sel_sh <= '1;
    end else begin
      scl_sh[0] <= scl_i;
      sda_sh[0] <= sda_i;
      sel_sh[0] <= sel_n_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        scl_sh[i] <= scl_sh[i-1];
        sda_sh[i] <= sda_sh[i-1];
        sel_sh[i] <= sel_sh[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign unsel     = sel_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d & ~unsel;
  assign scl_fall  = ~scl_s & scl_d & ~unsel;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s & ~unsel;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/mgmt_bus_fsm.sv
module mgmt_bus_fsm
  import mgmt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              unsel,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic              wr_is_offset,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              rd_adv,
  output bus_st_e           state
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rw_q;
  logic              first_q;
  logic              mack_q;
  logic              byte_full;
  logic              hit_w;

  assign byte_full = (bit_cnt == CNT_FULL);
  assign hit_w     = addr_hit(rx_sh, DEV_ADDR);
  assign wr_byte   = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      rx_sh        <= '0;
      tx_sh        <= '0;
      rw_q         <= 1'b0;
      first_q      <= 1'b0;
      mack_q       <= 1'b0;
      sda_oe       <= 1'b0;
      wr_stb       <= 1'b0;
      wr_is_offset <= 1'b0;
      rd_adv       <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      rd_adv <= 1'b0;
      if (unsel || stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && byte_full) begin
              if (hit_w) begin
                rw_q   <= rx_sh[0];
                sda_oe <= 1'b1;
                state  <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_q) begin
                tx_sh  <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                state  <= ST_TX;
              end else begin
                sda_oe  <= 1'b0;
                first_q <= 1'b1;
                state   <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && byte_full) begin
              wr_stb       <= 1'b1;
              wr_is_offset <= first_q;
              first_q      <= 1'b0;
              sda_oe       <= 1'b1;
              state        <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (byte_full) begin
                sda_oe <= 1'b0;
                rd_adv <= 1'b1;
                state  <= ST_RACK;
              end else begin
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_sh   <= rd_byte;
                sda_oe  <= ~rd_byte[BYTE_W-1];
                bit_cnt <= '0;
                state   <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mgmt_page_map.sv
module mgmt_page_map
  import mgmt_pkg::*;
#(
  parameter int USER_PAGE = 2,
  parameter int EXT_PAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              wr_is_offset,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rd_adv,
  input  logic [BYTE_W-1:0] rf_rdata,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] ptr_q,
  output logic [BYTE_W-1:0] page_q,
  output logic              step_evt,
  output logic              rf_upper,
  output logic [BYTE_W-1:0] rf_page,
  output logic [OFFS_W-1:0] rf_addr,
  output logic              rf_we,
  output logic [BYTE_W-1:0] rf_wdata
);

  localparam int HALF_DEPTH = 1 << OFFS_W;
  localparam logic [BYTE_W-1:0] USER_PG = BYTE_W'(USER_PAGE);
  localparam logic [BYTE_W-1:0] EXT_CNT = BYTE_W'(EXT_PAGES);

  logic [BYTE_W-1:0] user_mem [HALF_DEPTH];
  region_e           region;
  logic              data_wr;

  assign region   = region_of(ptr_q, page_q, USER_PG, EXT_CNT);
  assign data_wr  = wr_stb & ~wr_is_offset;
  assign step_evt = data_wr | rd_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      page_q <= '0;
    end else begin
      if (wr_stb && wr_is_offset) begin
        ptr_q <= wr_byte;
      end else if (step_evt) begin
        ptr_q <= ptr_step(ptr_q);
      end
      if (data_wr && region == RG_PSEL) begin
        page_q <= wr_byte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (data_wr && region == RG_USER) begin
      user_mem[ptr_q[OFFS_W-1:0]] <= wr_byte;
    end
  end

  always_comb begin
    unique case (region)
      RG_LOW, RG_EXT: rd_byte = rf_rdata;
      RG_PSEL:        rd_byte = page_q;
      RG_USER:        rd_byte = user_mem[ptr_q[OFFS_W-1:0]];
      default:        rd_byte = '0;
    endcase
  end

  assign rf_upper = ptr_q[BYTE_W-1];
  assign rf_page  = page_q;
  assign rf_addr  = ptr_q[OFFS_W-1:0];
  assign rf_wdata = wr_byte;
  assign rf_we    = data_wr & ((region == RG_LOW) | (region == RG_EXT));

endmodule

// File: rtl/mgmt_i2c_slave.sv
module mgmt_i2c_slave
  import mgmt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2,
  parameter int         USER_PAGE   = 2,
  parameter int         EXT_PAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              sel_n_i,
  output logic              rf_upper_o,
  output logic [BYTE_W-1:0] rf_page_o,
  output logic [OFFS_W-1:0] rf_addr_o,
  output logic              rf_we_o,
  output logic [BYTE_W-1:0] rf_wdata_o,
  input  logic [BYTE_W-1:0] rf_rdata_i
);

  logic              scl_s, sda_s, unsel;
  logic              scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_stb, wr_is_offset, rd_adv, step_evt;
  logic [BYTE_W-1:0] wr_byte, rd_byte, ptr_q, page_q;
  bus_st_e           state;

  mgmt_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sel_n_i(sel_n_i),
    .scl_s(scl_s), .sda_s(sda_s), .unsel(unsel), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  mgmt_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .unsel(unsel), .sda_s(sda_s),
    .rd_byte(rd_byte), .sda_oe(sda_oe_o), .wr_stb(wr_stb),
    .wr_is_offset(wr_is_offset), .wr_byte(wr_byte), .rd_adv(rd_adv),
    .state(state)
  );

  mgmt_page_map #(.USER_PAGE(USER_PAGE), .EXT_PAGES(EXT_PAGES)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_is_offset(wr_is_offset),
    .wr_byte(wr_byte), .rd_adv(rd_adv), .rf_rdata(rf_rdata_i),
    .rd_byte(rd_byte), .ptr_q(ptr_q), .page_q(page_q), .step_evt(step_evt),
    .rf_upper(rf_upper_o), .rf_page(rf_page_o), .rf_addr(rf_addr_o),
    .rf_we(rf_we_o), .rf_wdata(rf_wdata_o)
  );

endmodule

// File: rtl/mgmt_i2c_checker.sv
module mgmt_i2c_checker #(
  parameter int USER_PAGE = 2,
  parameter int EXT_PAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       unsel,
  input logic       step_evt,
  input logic [7:0] ptr,
  input logic       rf_we,
  input logic       rf_upper,
  input logic [6:0] rf_addr,
  input logic [7:0] rf_page
);

  // R2 / R10: no drive in the cycle after the select input is seen high
  p_quiet_unsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    unsel |=> !sda_oe);

  // R3: SDA is only ever taken low while SCL is low
  p_drive_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R1: no acknowledge or data drive can start without select
  p_drive_needs_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(unsel));

  // R6: a pointer step keeps the half and moves the low seven bits by one
  p_ptr_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (ptr[7] == $past(ptr[7])) &&
                 (ptr[6:0] == 7'($past(ptr[6:0]) + 7'd1)));

  // R8: the page-select byte never reaches the register-file port
  p_psel_private_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_upper || rf_addr != 7'h7F));

  // R9: upper writes go out only for pages served by the port
  p_ext_page_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_upper) |-> (int'(rf_page) < EXT_PAGES && int'(rf_page) != USER_PAGE));

endmodule

bind mgmt_i2c_slave mgmt_i2c_checker #(
  .USER_PAGE(USER_PAGE), .EXT_PAGES(EXT_PAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_s(scl_s), .unsel(unsel),
  .step_evt(step_evt), .ptr(ptr_q), .rf_we(rf_we_o), .rf_upper(rf_upper_o),
  .rf_addr(rf_addr_o), .rf_page(rf_page_o)
);

// File: tb/mgmt_i2c_slave_bench.sv
module mgmt_i2c_slave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam int H = 8;
  localparam int NPG = 2;
  localparam int UPG = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mscl = 1'b1, msda = 1'b1, sel_n = 1'b0;
  logic sda_oe, sda_line;
  logic rf_upper, rf_we;
  logic [7:0] rf_page, rf_wdata, rf_rdata;
  logic [6:0] rf_addr;

  int errors = 0, checks = 0;
  bit done = 0;
  int mon_r3 = 0, mon_r2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = msda & ~sda_oe;

  mgmt_i2c_slave u_mgmt_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(mscl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .sel_n_i(sel_n), .rf_upper_o(rf_upper), .rf_page_o(rf_page),
    .rf_addr_o(rf_addr), .rf_we_o(rf_we), .rf_wdata_o(rf_wdata),
    .rf_rdata_i(rf_rdata)
  );

  // Environment register file served over the port.
  logic [7:0] lo_rf [128];
  logic [7:0] ext_rf [NPG][128];
  always_comb begin
    if (!rf_upper) rf_rdata = lo_rf[rf_addr];
    else if (rf_page < 8'(NPG)) rf_rdata = ext_rf[rf_page[0]][rf_addr];
    else rf_rdata = 8'h00;
  end
  always @(posedge clk) if (rf_we) begin
    if (!rf_upper) lo_rf[rf_addr] <= rf_wdata;
    else if (rf_page < 8'(NPG)) ext_rf[rf_page[0]][rf_addr] <= rf_wdata;
  end

  // Expected model.
  logic [7:0] e_lo [128];
  logic [7:0] e_ext [NPG][128];
  logic [7:0] e_user [128];
  bit         e_uval [128];
  logic [7:0] e_page = 8'h00;
  logic [7:0] e_ptr = 8'h00;

  function automatic logic [7:0] nxt(input logic [7:0] p);
    int lo;
    lo = (int'(p[6:0]) + 1) % 128;
    return {p[7], 7'(lo)};
  endfunction

  task automatic model_write(input logic [7:0] b);
    int o;
    o = int'(e_ptr[6:0]);
    if (!e_ptr[7]) begin
      if (o == 127) e_page = b; else e_lo[o] = b;
    end else if (int'(e_page) == UPG) begin
      e_user[o] = b; e_uval[o] = 1;
    end else if (int'(e_page) < NPG) begin
      e_ext[e_page[0]][o] = b;
    end
    e_ptr = nxt(e_ptr);
  endtask

  task automatic model_read(output logic [7:0] v, output bit known);
    int o;
    o = int'(e_ptr[6:0]);
    known = 1;
    if (!e_ptr[7]) v = (o == 127) ? e_page : e_lo[o];
    else if (int'(e_page) == UPG) begin v = e_user[o]; known = e_uval[o]; end
    else if (int'(e_page) < NPG) v = e_ext[e_page[0]][o];
    else v = 8'h00;
    e_ptr = nxt(e_ptr);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitors for drive timing and select gating.
  logic prev_oe = 1'b0;
  int   sel_hi = 0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && mscl) mon_r3++;
    prev_oe <= sda_oe;
    sel_hi = sel_n ? sel_hi + 1 : 0;
    if (rst_n && sel_hi > 4 && sda_oe) mon_r2++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    msda = 1; tick(Q); mscl = 1; tick(H); msda = 0; tick(H); mscl = 0; tick(Q);
  endtask
  task automatic m_stop;
    msda = 0; tick(Q); mscl = 1; tick(H); msda = 1; tick(H);
  endtask
  task automatic m_bit_w(input logic b);
    msda = b; tick(Q); mscl = 1; tick(H); mscl = 0; tick(Q);
  endtask
  task automatic m_bit_r(output logic b);
    msda = 1; tick(Q); mscl = 1; tick(H/2); b = sda_line; tick(H/2); mscl = 0; tick(Q);
  endtask
  task automatic m_byte_w(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
    m_bit_r(b);
    ack = !b;
  endtask
  task automatic m_byte_r(input bit ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin m_bit_r(b); d[i] = b; end
    m_bit_w(!ack);
  endtask

  logic [7:0] wbuf [8];

  task automatic bus_write(input logic [7:0] off, input int n);
    bit ack;
    m_start;
    m_byte_w(8'hA0, ack); chk(ack, "R1 write address ack", ack, 1);
    m_byte_w(off, ack);   chk(ack, "R4 offset ack", ack, 1);
    e_ptr = off;
    for (int i = 0; i < n; i++) begin
      m_byte_w(wbuf[i], ack); chk(ack, "R4 data ack", ack, 1);
      model_write(wbuf[i]);
    end
    m_stop;
  endtask

  task automatic bus_read(input logic [7:0] off, input int n, input string req);
    bit ack, known;
    logic [7:0] d, e;
    m_start;
    m_byte_w(8'hA0, ack); chk(ack, "R1 address ack", ack, 1);
    m_byte_w(off, ack);   chk(ack, "R4 offset ack", ack, 1);
    e_ptr = off;
    m_start;
    m_byte_w(8'hA1, ack); chk(ack, "R11 repeated start read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      m_byte_r(i != n - 1, d);
      model_read(e, known);
      if (known) chk(d == e, req, d, e);
    end
    m_stop;
  endtask

  task automatic set_page(input logic [7:0] p);
    wbuf[0] = p; bus_write(8'd127, 1);
  endtask

  initial begin
    bit ack;
    logic b;
    int dummy;
    dummy = $urandom(32'h5EED_0042);
    for (int i = 0; i < 128; i++) begin
      lo_rf[i] = 8'(i * 3 + 7); e_lo[i] = 8'(i * 3 + 7);
      e_user[i] = 8'h00; e_uval[i] = 0;
      for (int p = 0; p < NPG; p++) begin
        ext_rf[p][i] = 8'(i ^ (p * 8'h41)); e_ext[p][i] = 8'(i ^ (p * 8'h41));
      end
    end
    tick(5);
    chk(sda_oe == 0, "R2 reset: SDA released", sda_oe, 0);
    chk(rf_we == 0, "R7 reset: no write strobe", rf_we, 0);
    rst_n = 1; tick(5);

    // R8: page register resets to zero and reads back.
    bus_read(8'd127, 1, "R8 page register reset value");

    // R1: foreign address is not acknowledged.
    m_start; m_byte_w(8'hA2, ack); chk(!ack, "R1 foreign address nack", ack, 0); m_stop;

    // R4 R7: lower write, observed at the register-file port.
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    bus_write(8'd10, 3);
    chk(lo_rf[11] == 8'h22, "R7 port write lower", lo_rf[11], 8'h22);
    bus_read(8'd10, 3, "R5 sequential read lower");

    // R6 R8: read across 126 -> 127 (page) -> 0.
    bus_read(8'd126, 3, "R6 lower wrap read");

    // R9: user page, with upper wrap 255 -> 128.
    set_page(8'd2);
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
    bus_write(8'd254, 3);
    bus_read(8'd254, 3, "R6 upper wrap read user page");
    bus_read(8'd128, 1, "R9 user byte at 128");

    // R9: external page 1 through the port.
    set_page(8'd1);
    wbuf[0] = 8'h9E; bus_write(8'd130, 1);
    chk(ext_rf[1][2] == 8'h9E, "R9 port write upper page 1", ext_rf[1][2], 8'h9E);
    bus_read(8'd130, 1, "R9 read page 1");

    // R9: unserved page reads zero, ignores writes.
    set_page(8'd5);
    wbuf[0] = 8'hFF; bus_write(8'd140, 1);
    bus_read(8'd140, 1, "R9 unserved page reads zero");
    set_page(8'd2);
    bus_read(8'd254, 2, "R9 user data kept after page switch");

    // R2: unselected, no ack and no write.
    sel_n = 1; tick(6);
    m_start; m_byte_w(8'hA0, ack); chk(!ack, "R2 no ack while unselected", ack, 0);
    m_byte_w(8'd10, ack); m_byte_w(8'hEE, ack); m_stop;
    sel_n = 0; tick(6);
    bus_read(8'd10, 1, "R2 write ignored while unselected");

    // R10: select rises mid-byte.
    m_start; m_byte_w(8'hA0, ack); m_byte_w(8'd5, ack);
    m_bit_w(1'b1); m_bit_w(1'b1); m_bit_w(1'b0);
    sel_n = 1; tick(6);
    chk(sda_oe == 0, "R10 SDA released on abort", sda_oe, 0);
    sel_n = 0; tick(4);
    for (int i = 0; i < 5; i++) m_bit_w(1'b0);
    m_bit_r(b); chk(b == 1, "R10 no ack after abort", b, 1);
    m_stop;
    bus_read(8'd5, 1, "R10 aborted byte not stored");

    // R11: after stop, a byte without start is ignored.
    for (int i = 7; i >= 0; i--) m_bit_w(8'hA0 >> i);
    m_bit_r(b); chk(b == 1, "R11 idle after stop", b, 1);
    msda = 1; tick(H);

    // Random mix.
    for (int it = 0; it < 40; it++) begin
      int n;
      logic [7:0] off;
      logic [7:0] pgs [5];
      pgs[0] = 0; pgs[1] = 1; pgs[2] = 2; pgs[3] = 4; pgs[4] = 9;
      set_page(pgs[$urandom % 5]);
      off = 8'($urandom);
      n = 1 + int'($urandom % 4);
      if ($urandom % 2 == 1) begin
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        bus_write(off, n);
      end
      bus_read(off, n, "R5 random read back");
    end

    chk(mon_r3 == 0, "R3 drive changed with SCL high", mon_r3, 0);
    chk(mon_r2 == 0, "R2 drive while unselected", mon_r2, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule